// File: doc/BRIEF.md
# Write Leveling Calibration Controller

This block is the controller-side sequencer that lines up the outgoing data strobe with the memory clock as each DRAM rank sees it. On a start request it sends a mode-register write to rank 0 that puts the device into leveling mode. It then runs a search loop. In each pass it fires one strobe pulse, waits a programmable settle time, and samples a one-bit feedback line per byte lane. Between passes it raises the output delay code of every lane that has not yet resolved.

A lane resolves when it sees a clean rising edge on its feedback: a 0 reading first, then two 1 readings in a row at the same delay code. A lane that reaches the top code without such an edge is marked in error and keeps that top code. All lanes of a rank are searched in parallel. Once every lane has resolved, the controller sends a second mode-register write that takes the rank out of leveling mode, latches that rank's codes into its own result slot, and moves on to the next rank.

The delay line itself lies outside the block. It is driven from the live code output during training, and from the per-rank result outputs during normal writes.

Top module: `wl_wrlvl_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `cmd_valid_o` and `dqs_pulse_o` are 0, and every result code and every error flag is 0.
- R2: When `start_i` is sampled high while idle, the next cycle shows `busy_o`=1 and a command with `cmd_valid_o`=1, `cmd_type_o`=2'b01 (mode-register write; 2'b00 means no command), `cmd_rank_o`=0 and `cmd_data_o`=`mr_enter_i`.
- R3: `dqs_pulse_o` is high only between a rank's entry command (data `mr_enter_i`) and its exit command (data `mr_exit_i`).
- R4: At least `settle_i`+1 idle cycles separate a strobe pulse from the next pulse or the next change of `dly_code_o`. At least `settle_i`+1 idle cycles also separate a change of `dly_code_o` from the next pulse.
- R5: During a search a lane's delay code only steps up by one or returns to 0. The stored code is the first code at which the feedback reads 1 on two consecutive pulses, after an earlier 0 reading.
- R6: A single 1 reading followed by a 0 at the same code does not resolve the lane; the search goes on stepping up.
- R7: A lane that reaches the maximum code (2^CODE_W-1) without a confirmed rising edge gets its error flag set and stores the maximum code. The other lanes and ranks are still calibrated.
- R8: Feedback that reads 1 from code 0 onward, so that no 0 is ever seen, is not a rising edge. It ends in the error outcome of R7.
- R9: Each rank keeps its own results. Lane l of rank r sits in `wr_code_o[(r*N_LANES+l)*CODE_W +: CODE_W]` and `lvl_err_o[r*N_LANES+l]`. Calibrating one rank leaves the other ranks' slots unchanged.
- R10: For each rank, in ascending rank order, exactly one entry command and then one exit command is issued, with no strobe pulse in the same cycle as a command.
- R11: After the last exit command `busy_o` falls and `done_o` rises in the same cycle. `done_o` stays high until the next accepted start. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a full calibration of all ranks |
| settle_i | input | SETTLE_W | Settle cycles after a delay change and after a pulse |
| mr_enter_i | input | MR_W | Mode-register data that enters leveling mode |
| mr_exit_i | input | MR_W | Mode-register data that leaves leveling mode |
| fb_i | input | N_LANES | Sampled clock level returned per lane |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished, results valid |
| cmd_valid_o | output | 1 | Command present this cycle |
| cmd_type_o | output | 2 | Command type (01 = mode-register write) |
| cmd_rank_o | output | RANK_W | Target rank of the command |
| cmd_data_o | output | MR_W | Mode-register data of the command |
| dqs_pulse_o | output | 1 | One-cycle strobe pulse request |
| dly_code_o | output | N_LANES*CODE_W | Live per-lane delay code during the search |
| wr_code_o | output | N_RANKS*N_LANES*CODE_W | Stored per-rank, per-lane delay codes |
| lvl_err_o | output | N_RANKS*N_LANES | Per-rank, per-lane no-edge error flags |

## Verification
Some properties are checked on every cycle. Strobe pulses must stay inside the window between entry and exit, the settle gaps around pulses and code changes must hold, the codes may only step up by one or clear, and the start/busy/done handshake must behave. Other properties depend on what the DRAM returns, so only the bench scenarios can show them. A threshold stub plays the DRAM. Against it the bench checks that the stored code equals the first aligned code, that a one-shot glitch is rejected, that feedback high from code 0 or never high ends in the error flag, and that each rank's results land in their own slot.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_MRW = 2'd1
  } wl_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ENTER  = 3'd1,
    S_WAIT_D = 3'd2,
    S_PULSE  = 3'd3,
    S_WAIT_S = 3'd4,
    S_SAMPLE = 3'd5,
    S_DECIDE = 3'd6,
    S_EXIT   = 3'd7
  } wl_state_e;
endpackage

// File: rtl/wl_lane.sv
module wl_lane #(
  parameter int CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              fb_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [CODE_W-1:0] MaxCode = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic seen0_q, pend_q, lock_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0; seen0_q <= 1'b0; pend_q <= 1'b0; lock_q <= 1'b0; err_q <= 1'b0;
    end else if (clear_i) begin
      code_q <= '0; seen0_q <= 1'b0; pend_q <= 1'b0; lock_q <= 1'b0; err_q <= 1'b0;
    end else if (sample_i && !lock_q && !err_q) begin
      if (pend_q && fb_i) begin
        lock_q <= 1'b1;                       // second agreeing 1 at same code
      end else if (!pend_q && seen0_q && fb_i) begin
        pend_q <= 1'b1;                       // hold code, confirm on next pulse
      end else begin
        pend_q <= 1'b0;
        if (!fb_i) seen0_q <= 1'b1;
        if (code_q == MaxCode) err_q <= 1'b1;
        else                   code_q <= code_q + 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign done_o = lock_q | err_q;
  assign err_o  = err_q;
endmodule

// File: rtl/wl_seq.sv
module wl_seq
  import wl_pkg::*;
#(
  parameter int N_RANKS  = 2,
  parameter int SETTLE_W = 4,
  localparam int RANK_W  = (N_RANKS > 1) ? $clog2(N_RANKS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                all_done_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                cmd_valid_o,
  output logic                enter_o,
  output logic [RANK_W-1:0]   rank_o,
  output logic                pulse_o,
  output logic                sample_o,
  output logic                commit_o
);
  localparam logic [RANK_W-1:0] LastRank = RANK_W'(N_RANKS - 1);

  wl_state_e state_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [RANK_W-1:0] rank_q;
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; cnt_q <= '0; rank_q <= '0; done_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_ENTER; rank_q <= '0; done_q <= 1'b0;
        end
        S_ENTER: begin state_q <= S_WAIT_D; cnt_q <= settle_i; end
        S_WAIT_D: if (cnt_q == '0) state_q <= S_PULSE; else cnt_q <= cnt_q - 1'b1;
        S_PULSE: begin state_q <= S_WAIT_S; cnt_q <= settle_i; end
        S_WAIT_S: if (cnt_q == '0) state_q <= S_SAMPLE; else cnt_q <= cnt_q - 1'b1;
        S_SAMPLE: state_q <= S_DECIDE;
        S_DECIDE: if (all_done_i) state_q <= S_EXIT;
                  else begin state_q <= S_WAIT_D; cnt_q <= settle_i; end
        S_EXIT: if (rank_q == LastRank) begin
          state_q <= S_IDLE; done_q <= 1'b1;
        end else begin
          state_q <= S_ENTER; rank_q <= rank_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign cmd_valid_o = (state_q == S_ENTER) || (state_q == S_EXIT);
  assign enter_o     = (state_q == S_ENTER);
  assign rank_o      = rank_q;
  assign pulse_o     = (state_q == S_PULSE);
  assign sample_o    = (state_q == S_SAMPLE);
  assign commit_o    = (state_q == S_EXIT);
endmodule

// File: rtl/wl_result.sv
module wl_result #(
  parameter int N_RANKS = 2,
  parameter int N_LANES = 4,
  parameter int CODE_W  = 6,
  localparam int RANK_W = (N_RANKS > 1) ? $clog2(N_RANKS) : 1,
  localparam int SLOT_W = N_LANES * CODE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  input  logic [RANK_W-1:0]           rank_i,
  input  logic [SLOT_W-1:0]           codes_i,
  input  logic [N_LANES-1:0]          errs_i,
  output logic [N_RANKS*SLOT_W-1:0]   codes_o,
  output logic [N_RANKS*N_LANES-1:0]  errs_o
);
  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        codes_o[r*SLOT_W +: SLOT_W]   <= '0;
        errs_o[r*N_LANES +: N_LANES] <= '0;
      end else if (commit_i && (rank_i == RANK_W'(r))) begin
        codes_o[r*SLOT_W +: SLOT_W]   <= codes_i;
        errs_o[r*N_LANES +: N_LANES] <= errs_i;
      end
    end
  end
endmodule

// File: rtl/wl_wrlvl_ctrl.sv
module wl_wrlvl_ctrl
  import wl_pkg::*;
#(
  parameter int N_RANKS  = 2,
  parameter int N_LANES  = 4,
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4,
  parameter int MR_W     = 16,
  localparam int RANK_W  = (N_RANKS > 1) ? $clog2(N_RANKS) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [SETTLE_W-1:0]                settle_i,
  input  logic [MR_W-1:0]                    mr_enter_i,
  input  logic [MR_W-1:0]                    mr_exit_i,
  input  logic [N_LANES-1:0]                 fb_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic                               cmd_valid_o,
  output logic [1:0]                         cmd_type_o,
  output logic [RANK_W-1:0]                  cmd_rank_o,
  output logic [MR_W-1:0]                    cmd_data_o,
  output logic                               dqs_pulse_o,
  output logic [N_LANES*CODE_W-1:0]          dly_code_o,
  output logic [N_RANKS*N_LANES*CODE_W-1:0]  wr_code_o,
  output logic [N_RANKS*N_LANES-1:0]         lvl_err_o
);
  logic enter, sample, commit, cmd_valid;
  logic [N_LANES-1:0] lane_done, lane_err;

  wl_seq #(.N_RANKS(N_RANKS), .SETTLE_W(SETTLE_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .settle_i,
    .all_done_i (&lane_done),
    .busy_o, .done_o,
    .cmd_valid_o(cmd_valid),
    .enter_o    (enter),
    .rank_o     (cmd_rank_o),
    .pulse_o    (dqs_pulse_o),
    .sample_o   (sample),
    .commit_o   (commit)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    wl_lane #(.CODE_W(CODE_W)) u_lane (
      .clk_i, .rst_ni,
      .clear_i (commit),
      .sample_i(sample),
      .fb_i    (fb_i[l]),
      .code_o  (dly_code_o[l*CODE_W +: CODE_W]),
      .done_o  (lane_done[l]),
      .err_o   (lane_err[l])
    );
  end

  wl_result #(.N_RANKS(N_RANKS), .N_LANES(N_LANES), .CODE_W(CODE_W)) u_result (
    .clk_i, .rst_ni,
    .commit_i(commit),
    .rank_i  (cmd_rank_o),
    .codes_i (dly_code_o),
    .errs_i  (lane_err),
    .codes_o (wr_code_o),
    .errs_o  (lvl_err_o)
  );

  assign cmd_valid_o = cmd_valid;
  assign cmd_type_o  = cmd_valid ? CMD_MRW : CMD_NOP;
  assign cmd_data_o  = !cmd_valid ? '0 : (enter ? mr_enter_i : mr_exit_i);
endmodule

// File: rtl/wl_wrlvl_ctrl_chk.sv
module wl_wrlvl_ctrl_chk
  import wl_pkg::*;
#(
  parameter int N_RANKS  = 2,
  parameter int N_LANES  = 4,
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4,
  parameter int MR_W     = 16,
  localparam int RANK_W  = (N_RANKS > 1) ? $clog2(N_RANKS) : 1,
  localparam int GAP_W   = SETTLE_W + 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               start_i,
  input logic [SETTLE_W-1:0]                settle_i,
  input logic [MR_W-1:0]                    mr_enter_i,
  input logic [MR_W-1:0]                    mr_exit_i,
  input logic [N_LANES-1:0]                 fb_i,
  input logic                               busy_o,
  input logic                               done_o,
  input logic                               cmd_valid_o,
  input logic [1:0]                         cmd_type_o,
  input logic [RANK_W-1:0]                  cmd_rank_o,
  input logic [MR_W-1:0]                    cmd_data_o,
  input logic                               dqs_pulse_o,
  input logic [N_LANES*CODE_W-1:0]          dly_code_o,
  input logic [N_RANKS*N_LANES*CODE_W-1:0]  wr_code_o,
  input logic [N_RANKS*N_LANES-1:0]         lvl_err_o
);
  localparam logic [GAP_W-1:0] GapMax = {GAP_W{1'b1}};

  logic lvl_q;
  logic [GAP_W-1:0] since_pulse_q, since_chg_q;
  logic [N_LANES*CODE_W-1:0] prev_code_q;
  logic chg;

  assign chg = (dly_code_o != prev_code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0; since_pulse_q <= GapMax; since_chg_q <= GapMax; prev_code_q <= '0;
    end else begin
      if (cmd_valid_o && cmd_type_o == CMD_MRW) begin
        if (cmd_data_o == mr_enter_i)     lvl_q <= 1'b1;
        else if (cmd_data_o == mr_exit_i) lvl_q <= 1'b0;
      end
      since_pulse_q <= dqs_pulse_o ? '0 : ((since_pulse_q == GapMax) ? GapMax : since_pulse_q + 1'b1);
      since_chg_q   <= chg ? '0 : ((since_chg_q == GapMax) ? GapMax : since_chg_q + 1'b1);
      prev_code_q   <= dly_code_o;
    end
  end

  assert_start_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cmd_valid_o && cmd_type_o == CMD_MRW &&
                              cmd_rank_o == '0 && cmd_data_o == mr_enter_i));

  assert_pulse_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_pulse_o |-> lvl_q);

  assert_pulse_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_pulse_o |-> (since_pulse_q > GAP_W'(settle_i) && since_chg_q > GAP_W'(settle_i)));

  assert_change_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |-> (since_pulse_q > GAP_W'(settle_i)));

  for (genvar l = 0; l < N_LANES; l++) begin : g_step
    assert_code_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dly_code_o[l*CODE_W +: CODE_W] != prev_code_q[l*CODE_W +: CODE_W]) |->
      (dly_code_o[l*CODE_W +: CODE_W] == prev_code_q[l*CODE_W +: CODE_W] + 1'b1 ||
       dly_code_o[l*CODE_W +: CODE_W] == '0));
  end

  assert_cmd_no_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !dqs_pulse_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind wl_wrlvl_ctrl wl_wrlvl_ctrl_chk #(
  .N_RANKS(N_RANKS), .N_LANES(N_LANES), .CODE_W(CODE_W),
  .SETTLE_W(SETTLE_W), .MR_W(MR_W)
) u_chk (.*);

// File: tb/wl_wrlvl_ctrl_bench.sv
module wl_wrlvl_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANKS  = 2;
  localparam int N_LANES  = 4;
  localparam int CODE_W   = 6;
  localparam int SETTLE_W = 4;
  localparam int MR_W     = 16;
  localparam int RANK_W   = 1;
  localparam int MAXC     = (1 << CODE_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [SETTLE_W-1:0] settle_i = '0;
  logic [MR_W-1:0] mr_enter = 16'h0084;
  logic [MR_W-1:0] mr_exit  = 16'h8004;
  logic [N_LANES-1:0] stub_fb = '0;
  logic busy_o, done_o, cmd_valid_o, dqs_pulse_o;
  logic [1:0] cmd_type_o;
  logic [RANK_W-1:0] cmd_rank_o;
  logic [MR_W-1:0] cmd_data_o;
  logic [N_LANES*CODE_W-1:0] dly_code_o;
  logic [N_RANKS*N_LANES*CODE_W-1:0] wr_code_o;
  logic [N_RANKS*N_LANES-1:0] lvl_err_o;

  int checks = 0;
  int errors = 0;
  int thr   [N_RANKS][N_LANES];
  int glt   [N_RANKS][N_LANES];
  bit gused [N_RANKS][N_LANES];
  int stub_rank = 0;
  int cur_settle = 0;

  // monitor state (written only by the monitor)
  int cmd_total = 0, pulse_bad = 0, gap_bad = 0;
  int ring_rank [16];
  bit ring_ent  [16];
  bit mon_lvl = 1'b0;
  int since_p = 1000, since_c = 1000;
  logic [N_LANES*CODE_W-1:0] prev_dly = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wl_wrlvl_ctrl #(.N_RANKS(N_RANKS), .N_LANES(N_LANES), .CODE_W(CODE_W),
                  .SETTLE_W(SETTLE_W), .MR_W(MR_W)) u_wl_wrlvl_ctrl (
    .clk_i, .rst_ni, .start_i, .settle_i,
    .mr_enter_i(mr_enter), .mr_exit_i(mr_exit), .fb_i(stub_fb),
    .busy_o, .done_o, .cmd_valid_o, .cmd_type_o, .cmd_rank_o, .cmd_data_o,
    .dqs_pulse_o, .dly_code_o, .wr_code_o, .lvl_err_o
  );

  // DRAM stub: on each strobe pulse, return 1 once the lane code reaches its threshold
  always @(posedge clk_i) begin
    if (cmd_valid_o && cmd_data_o == mr_enter) begin
      stub_rank <= int'(cmd_rank_o);
      for (int l = 0; l < N_LANES; l++) gused[int'(cmd_rank_o)][l] <= 1'b0;
    end
    if (dqs_pulse_o) begin
      for (int l = 0; l < N_LANES; l++) begin
        int code;
        code = int'(dly_code_o[l*CODE_W +: CODE_W]);
        if (code == glt[stub_rank][l] && !gused[stub_rank][l]) begin
          stub_fb[l] <= 1'b1;
          gused[stub_rank][l] <= 1'b1;
        end else begin
          stub_fb[l] <= (code >= thr[stub_rank][l]);
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit chg;
      chg = (dly_code_o != prev_dly);
      if (cmd_valid_o) begin
        ring_rank[cmd_total % 16] = int'(cmd_rank_o);
        ring_ent[cmd_total % 16]  = (cmd_data_o == mr_enter);
        mon_lvl = (cmd_data_o == mr_enter);
        cmd_total++;
      end
      if (dqs_pulse_o) begin
        if (!mon_lvl) pulse_bad++;
        if (since_p <= cur_settle || since_c <= cur_settle) gap_bad++;
      end
      if (chg && since_p <= cur_settle) gap_bad++;
      since_p = dqs_pulse_o ? 0 : since_p + 1;
      since_c = chg ? 0 : since_c + 1;
      prev_dly = dly_code_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int t);
    return (t >= 1 && t <= MAXC) ? t : MAXC;
  endfunction

  function automatic bit exp_err(int t);
    return !(t >= 1 && t <= MAXC);
  endfunction

  task automatic run_one(input int settle, input bit mid_start);
    int c0, p0, g0, cyc;
    logic [N_RANKS*N_LANES-1:0] exp_errv;
    @(negedge clk_i);
    settle_i = SETTLE_W'(settle);
    cur_settle = settle;
    mr_enter = 16'($urandom_range(0, 16'h7fff));
    mr_exit  = mr_enter ^ 16'h8000;
    c0 = cmd_total; p0 = pulse_bad; g0 = gap_bad;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2: entry command to rank 0 one cycle after start
    chk(busy_o && cmd_valid_o && cmd_type_o == 2'b01 && cmd_rank_o == '0 &&
        cmd_data_o == mr_enter, "R2 entry command", int'(cmd_data_o), int'(mr_enter));
    cyc = 0;
    while (!done_o && cyc < 40000) begin
      @(negedge clk_i);
      cyc++;
      if (mid_start) start_i = (cyc == 25);
    end
    start_i = 1'b0;
    chk(done_o && !busy_o, "R11 watchdog/done", int'(done_o), 1);
    exp_errv = '0;
    for (int r = 0; r < N_RANKS; r++) begin
      for (int l = 0; l < N_LANES; l++) begin
        int t, act;
        string tag;
        t = thr[r][l];
        act = int'(wr_code_o[(r*N_LANES+l)*CODE_W +: CODE_W]);
        exp_errv[r*N_LANES+l] = exp_err(t);
        if (t == 0)                             tag = "R8 edge from code 0";
        else if (t > MAXC)                      tag = "R7 no edge";
        else if (glt[r][l] >= 1 && glt[r][l] < t) tag = "R6 glitch rejected";
        else                                    tag = "R5 aligned code";
        chk(act == exp_code(t), tag, act, exp_code(t));
        chk(lvl_err_o[r*N_LANES+l] == exp_err(t), tag, int'(lvl_err_o[r*N_LANES+l]),
            int'(exp_err(t)));
      end
    end
    chk(lvl_err_o == exp_errv, "R9 per-rank error slots", int'(lvl_err_o), int'(exp_errv));
    chk(cmd_total - c0 == 2*N_RANKS, "R10 command count", cmd_total - c0, 2*N_RANKS);
    for (int k = 0; k < 2*N_RANKS; k++) begin
      int idx;
      idx = (c0 + k) % 16;
      chk(ring_rank[idx] == k/2 && ring_ent[idx] == ((k % 2) == 0), "R10 command order",
          ring_rank[idx]*2 + int'(!ring_ent[idx]), k);
    end
    chk(pulse_bad == p0, "R3 pulse outside leveling", pulse_bad - p0, 0);
    chk(gap_bad == g0, "R4 settle gap", gap_bad - g0, 0);
    repeat (5) @(negedge clk_i);
    chk(done_o && !busy_o, "R11 done holds", int'(done_o), 1);
  endtask

  task automatic set_rank(input int r, input int t0, input int t1, input int t2, input int t3);
    thr[r][0] = t0; thr[r][1] = t1; thr[r][2] = t2; thr[r][3] = t3;
    for (int l = 0; l < N_LANES; l++) glt[r][l] = -1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < N_RANKS; r++) set_rank(r, 64, 64, 64, 64);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !done_o && !cmd_valid_o && !dqs_pulse_o, "R1 reset controls",
        int'({busy_o, done_o, cmd_valid_o, dqs_pulse_o}), 0);
    chk(wr_code_o == '0 && lvl_err_o == '0, "R1 reset results", int'(lvl_err_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // directed corners: lowest, highest, from-zero, never
    set_rank(0, 1, MAXC, 0, 64);
    set_rank(1, 32, 5, 64, 2);
    run_one(0, 1'b0);
    // glitches below threshold, start pulse while busy
    set_rank(0, 20, 40, 3, 10);
    set_rank(1, 7, 60, 1, 33);
    glt[0][0] = 12; glt[0][1] = 1; glt[1][1] = 59; glt[1][3] = 0;
    run_one(2, 1'b1);
    // constrained random
    for (int n = 0; n < 10; n++) begin
      for (int r = 0; r < N_RANKS; r++) begin
        for (int l = 0; l < N_LANES; l++) begin
          int sel;
          sel = int'($urandom_range(0, 19));
          if (sel == 0)      thr[r][l] = 0;
          else if (sel == 1) thr[r][l] = 64;
          else if (sel == 2) thr[r][l] = MAXC;
          else               thr[r][l] = int'($urandom_range(1, MAXC));
          glt[r][l] = -1;
          if (thr[r][l] > 1 && thr[r][l] <= MAXC && $urandom_range(0, 2) == 0)
            glt[r][l] = int'($urandom_range(1, thr[r][l] - 1));
        end
      end
      run_one(int'($urandom_range(0, 5)), n[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule